// File: doc/BRIEF.md
# Ring Telegram Extract/Insert Engine

This block is the cut-through frame engine of a slave node on a forwarding ring. Bytes reach it one per clock from a media front end, qualified by a data-valid strobe. Every byte leaves one clock later, so a passing frame is never held. While the frame streams through, a state machine checks a two-byte header. It then steps through the telegram fields: target address, control word, status, time stamp, eight payload bytes and a four-byte CRC-32.

When the telegram targets this node, the engine can read it, write it, or do both. A read copies the payload into a staging register. The payload reaches the receive FIFO as four 16-bit words, or goes to the clock block over a 64-bit strobe, but only after the CRC-32 over the payload has passed. A write replaces the outgoing payload with local return data and recomputes the outgoing CRC. On a telegram that both reads and writes, the read takes the original bytes before the write replaces them. A one-cycle completion pulse tells the interrupt unit that a payload has been handed over.

Top module: `ring_telegram_node`

## Requirements
- R1: Every input byte appears on the output exactly one clock later, with `out_valid` following `in_valid`. Bytes are unchanged unless R8 replaces them.
- R2: Frame byte 0 must be 0xC5 and byte 1 must be 0x1A. Otherwise the frame is forwarded unchanged, nothing is extracted, and the next frame after `in_valid` falls is handled normally.
- R3: Byte 2 is the target address, byte 3 the control word, byte 4 the status, byte 5 the time stamp, bytes 6 to 13 the payload and bytes 14 to 17 the CRC. In the control word, bit 0 requests a read, bit 1 a write and bit 7 marks a sync payload. Bits 3:2 give the motion mode (0 position, 1 velocity, 2 acceleration, 3 IO); on an addressed telegram they are latched to `cmd_mode` and held until the next one.
- R4: An addressed read that passes its CRC pushes four FIFO words. Word k is {payload byte 2k+1, payload byte 2k}, and the words are pushed in order k = 0 to 3.
- R5: The CRC uses the reflected 0x04C11DB7 polynomial with initial value all ones and a final inversion, sent least significant byte first. On a mismatch nothing is pushed and no completion pulse is raised.
- R6: `rcf_pulse` is high for exactly one cycle for each payload handed over, and at no other time.
- R7: An addressed read with control bit 7 set sends the payload to `sync_data` (payload byte 0 in bits 7:0) with a single `sync_wr` strobe, and leaves the FIFO unchanged.
- R8: An addressed write replaces output bytes 6 to 13 with `ret_data`, or with `sync_time` when bit 7 is set, byte 0 taken from bits 7:0. Output bytes 14 to 17 then carry the CRC of the new payload. When the telegram also reads, the FIFO gets the original payload.
- R9: A telegram whose status bit 7 is set (returning to the master) is neither extracted nor rewritten.
- R10: When fewer than four FIFO entries are free, an addressed read is dropped whole: no word is pushed and no pulse is raised.
- R11: A frame that ends before its last CRC byte pushes nothing, and the next frame is handled normally.
- R12: The FIFO presents its head word on `rxf_data`. `rxf_pop` removes it, `rxf_empty` shows an empty FIFO, and the word order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_addr | input | 8 | Address this node answers to |
| in_valid | input | 1 | Incoming byte qualifier / frame envelope |
| in_data | input | 8 | Incoming frame byte |
| out_valid | output | 1 | Forwarded byte qualifier |
| out_data | output | 8 | Forwarded byte |
| ret_data | input | 64 | Local return payload for write telegrams |
| sync_time | input | 64 | Local time inserted into sync write telegrams |
| cmd_mode | output | 2 | Latched motion mode of the last addressed telegram |
| rcf_pulse | output | 1 | Receive-complete pulse to the interrupt unit |
| sync_wr | output | 1 | Strobe for a sync payload |
| sync_data | output | 64 | Sync payload to the clock block |
| rxf_pop | input | 1 | Remove the FIFO head word |
| rxf_data | output | 16 | FIFO head word |
| rxf_empty | output | 1 | FIFO holds no word |

## Verification
A wrong field counter or state shows up at the output within the telegram it corrupts. Replaced bytes land on the wrong positions, or the regenerated CRC bytes differ from the expected values, and the bench compares every forwarded byte at its exact one-cycle slot. A fault in the CRC gate or the room check shows up a few cycles after the frame: a completion pulse that should not be there, or one that is missing. A fault in word packing shows up when the FIFO is drained, as a word with its bytes swapped or out of order. The bench mixes directed corner frames with randomly built frames whose outcome a bench model predicts.

// File: rtl/ring_tlg_pkg.sv
package ring_tlg_pkg;

    localparam logic [7:0]  HDR_B0        = 8'hC5;
    localparam logic [7:0]  HDR_B1        = 8'h1A;
    localparam int          PAY_BYTES     = 8;
    localparam int          CRC_BYTES     = 4;
    localparam int          WORD_W        = 16;
    localparam int          WORDS_PER_TLG = PAY_BYTES * 8 / WORD_W;
    localparam int          CW_RD         = 0;
    localparam int          CW_WR         = 1;
    localparam int          CW_MODE_LO    = 2;
    localparam int          CW_SYNC       = 7;
    localparam int          ST_RETURN     = 7;
    localparam logic [3:0]  CNT_PAY_LAST  = 4'(PAY_BYTES);
    localparam logic [3:0]  CNT_CRC_LAST  = 4'(PAY_BYTES + CRC_BYTES);
    localparam logic [31:0] CRC_POLY_R    = 32'hEDB88320;

    typedef enum logic [3:0] {
        ST_IDLE, ST_HEADER, ST_ADDRESS, ST_CONTROL, ST_STATUS,
        ST_DATA, ST_NOTIFY, ST_TAIL, ST_ERROR
    } tlg_state_e;

    typedef enum logic [1:0] {K_FWD, K_INS_DATA, K_INS_CRC} slot_kind_e;

    typedef struct packed {
        slot_kind_e  kind;
        logic [2:0]  idx;
    } slot_t;

    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/tlg_rx_fifo.sv
module tlg_rx_fifo
    import ring_tlg_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = WORD_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push,
    input  logic [WIDTH-1:0]               wdata,
    input  logic                           pop,
    output logic [WIDTH-1:0]               rdata,
    output logic                           empty,
    output logic [$clog2(DEPTH+1)-1:0]     level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic             do_push, do_pop;

    assign do_push = push && (level != CW'(DEPTH));
    assign do_pop  = pop && (level != '0);
    assign rdata   = mem[rp];
    assign empty   = (level == '0);

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            case ({do_push, do_pop})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        push |-> (level != CW'(DEPTH)));

    assert_level_bound_R12: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH));

endmodule

// File: rtl/tlg_splice.sv
module tlg_splice
    import ring_tlg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  slot_t       slot,
    input  logic        load_src,
    input  logic        src_sync,
    input  logic [63:0] ret_data,
    input  logic [63:0] sync_time,
    output logic        out_valid,
    output logic [7:0]  out_data
);
    logic [63:0] src_q;
    logic [31:0] tx_crc;
    logic [31:0] tx_fin;
    logic [7:0]  src_byte;

    assign tx_fin   = ~tx_crc;
    assign src_byte = src_q[{slot.idx, 3'b000} +: 8];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            src_q     <= '0;
            tx_crc    <= '1;
        end else begin
            out_valid <= in_valid;
            if (load_src) begin
                src_q  <= src_sync ? sync_time : ret_data;
                tx_crc <= '1;
            end
            case (slot.kind)
                K_INS_DATA: begin
                    out_data <= src_byte;
                    tx_crc   <= crc32_step(tx_crc, src_byte);
                end
                K_INS_CRC: out_data <= tx_fin[{slot.idx[1:0], 3'b000} +: 8];
                default:   out_data <= in_data;
            endcase
        end
    end

endmodule

// File: rtl/tlg_fsm.sv
module tlg_fsm
    import ring_tlg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        node_addr,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              fifo_room,
    output slot_t             slot,
    output logic              load_src,
    output logic              src_sync,
    output logic              fifo_push,
    output logic [WORD_W-1:0] fifo_wdata,
    output logic              sync_wr,
    output logic [63:0]       sync_data,
    output logic              rcf,
    output logic [1:0]        cmd_mode
);
    tlg_state_e  st;
    logic [3:0]  cnt;
    logic        hit_q, rd_q, wr_q, sync_q, act_rd, act_wr, crc_ok;
    logic [63:0] rx_buf;
    logic [31:0] rx_crc, rx_fin;
    logic [1:0]  mode_q;
    logic [2:0]  d_idx, c_idx;
    logic        in_pay, in_crc, crc_byte_ok, last_notify;

    assign d_idx       = 3'(cnt - 4'd1);
    assign c_idx       = 3'(cnt - CNT_PAY_LAST - 4'd1);
    assign in_pay      = (st == ST_DATA) && (cnt >= 4'd1) && (cnt <= CNT_PAY_LAST);
    assign in_crc      = (st == ST_DATA) && (cnt > CNT_PAY_LAST);
    assign rx_fin      = ~rx_crc;
    assign crc_byte_ok = (in_data == rx_fin[{c_idx[1:0], 3'b000} +: 8]);
    assign last_notify = (st == ST_NOTIFY) && (sync_q || cnt[1:0] == 2'(WORDS_PER_TLG - 1));

    always_comb begin
        slot = '{kind: K_FWD, idx: 3'd0};
        if (in_valid && act_wr && in_pay)      slot = '{kind: K_INS_DATA, idx: d_idx};
        else if (in_valid && act_wr && in_crc) slot = '{kind: K_INS_CRC, idx: c_idx};
    end

    assign load_src   = (st == ST_STATUS) && in_valid;
    assign src_sync   = sync_q;
    assign fifo_push  = (st == ST_NOTIFY) && !sync_q;
    assign fifo_wdata = rx_buf[{cnt[1:0], 4'b0000} +: WORD_W];
    assign sync_wr    = (st == ST_NOTIFY) && sync_q;
    assign sync_data  = rx_buf;
    assign rcf        = last_notify;
    assign cmd_mode   = mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            hit_q  <= 1'b0;
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
            sync_q <= 1'b0;
            act_rd <= 1'b0;
            act_wr <= 1'b0;
            crc_ok <= 1'b0;
            rx_buf <= '0;
            rx_crc <= '1;
            mode_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (in_valid) st <= (in_data == HDR_B0) ? ST_HEADER : ST_ERROR;
                ST_HEADER: begin
                    if (!in_valid) st <= ST_IDLE;
                    else           st <= (in_data == HDR_B1) ? ST_ADDRESS : ST_ERROR;
                end
                ST_ADDRESS: begin
                    if (!in_valid) st <= ST_IDLE;
                    else begin
                        hit_q <= (in_data == node_addr);
                        st    <= ST_CONTROL;
                    end
                end
                ST_CONTROL: begin
                    if (!in_valid) st <= ST_IDLE;
                    else begin
                        rd_q   <= in_data[CW_RD];
                        wr_q   <= in_data[CW_WR];
                        sync_q <= in_data[CW_SYNC];
                        if (hit_q) mode_q <= in_data[CW_MODE_LO +: 2];
                        st <= ST_STATUS;
                    end
                end
                ST_STATUS: begin
                    if (!in_valid) st <= ST_IDLE;
                    else begin
                        act_rd <= hit_q && rd_q && !in_data[ST_RETURN];
                        act_wr <= hit_q && wr_q && !in_data[ST_RETURN];
                        crc_ok <= 1'b1;
                        rx_crc <= '1;
                        cnt    <= '0;
                        st     <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (!in_valid) begin
                        st     <= ST_IDLE;
                        act_wr <= 1'b0;
                    end else begin
                        cnt <= cnt + 4'd1;
                        if (in_pay) begin
                            rx_buf[{d_idx, 3'b000} +: 8] <= in_data;
                            rx_crc <= crc32_step(rx_crc, in_data);
                        end
                        if (in_crc) crc_ok <= crc_ok && crc_byte_ok;
                        if (cnt == CNT_CRC_LAST) begin
                            cnt    <= '0;
                            act_wr <= 1'b0;
                            if (act_rd && crc_ok && crc_byte_ok && (sync_q || fifo_room))
                                st <= ST_NOTIFY;
                            else if (act_rd)
                                st <= ST_ERROR;
                            else
                                st <= ST_TAIL;
                        end
                    end
                end
                ST_NOTIFY: begin
                    if (last_notify) begin
                        cnt <= '0;
                        st  <= in_valid ? ST_TAIL : ST_IDLE;
                    end else begin
                        cnt <= cnt + 4'd1;
                    end
                end
                default: if (!in_valid) st <= ST_IDLE;
            endcase
        end
    end

    assert_notify_gated_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_NOTIFY) |-> (act_rd && crc_ok));

    assert_rcf_single_R6: assert property (@(posedge clk) disable iff (rst)
        rcf |=> !rcf);

    assert_sync_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        sync_wr |-> !fifo_push);

    assert_mode_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (st != ST_CONTROL) |=> $stable(mode_q));

endmodule

// File: rtl/ring_telegram_node.sv
module ring_telegram_node
    import ring_tlg_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        node_addr,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic [63:0]       ret_data,
    input  logic [63:0]       sync_time,
    output logic [1:0]        cmd_mode,
    output logic              rcf_pulse,
    output logic              sync_wr,
    output logic [63:0]       sync_data,
    input  logic              rxf_pop,
    output logic [WORD_W-1:0] rxf_data,
    output logic              rxf_empty
);
    localparam int LW = $clog2(FIFO_DEPTH + 1);

    slot_t             slot;
    logic              load_src, src_sync, fifo_push, fifo_room;
    logic [WORD_W-1:0] fifo_wdata;
    logic [LW-1:0]     fifo_level;

    assign fifo_room = (LW'(FIFO_DEPTH) - fifo_level) >= LW'(WORDS_PER_TLG);

    tlg_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .node_addr  (node_addr),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .fifo_room  (fifo_room),
        .slot       (slot),
        .load_src   (load_src),
        .src_sync   (src_sync),
        .fifo_push  (fifo_push),
        .fifo_wdata (fifo_wdata),
        .sync_wr    (sync_wr),
        .sync_data  (sync_data),
        .rcf        (rcf_pulse),
        .cmd_mode   (cmd_mode)
    );

    tlg_splice u_splice (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .slot      (slot),
        .load_src  (load_src),
        .src_sync  (src_sync),
        .ret_data  (ret_data),
        .sync_time (sync_time),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    tlg_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_push),
        .wdata (fifo_wdata),
        .pop   (rxf_pop),
        .rdata (rxf_data),
        .empty (rxf_empty),
        .level (fifo_level)
    );

endmodule

// File: tb/test_ring_telegram_node.sv
module test_ring_telegram_node;
    localparam logic [7:0] NODE  = 8'h2A;
    localparam int         DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  node_addr, in_data, out_data;
    logic        in_valid, out_valid, rcf_pulse, sync_wr, rxf_pop, rxf_empty;
    logic [63:0] ret_data, sync_time, sync_data;
    logic [1:0]  cmd_mode;
    logic [15:0] rxf_data;

    always #4 clk = ~clk;

    ring_telegram_node #(.FIFO_DEPTH(DEPTH)) i_ring_telegram_node (
        .clk(clk), .rst(rst), .node_addr(node_addr), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .ret_data(ret_data), .sync_time(sync_time),
        .cmd_mode(cmd_mode), .rcf_pulse(rcf_pulse), .sync_wr(sync_wr), .sync_data(sync_data),
        .rxf_pop(rxf_pop), .rxf_data(rxf_data), .rxf_empty(rxf_empty)
    );

    int          n_vec = 0;
    int          n_bad = 0;
    int          rcf_n = 0;
    int          syn_n = 0;
    logic [63:0] syn_got = '0;
    logic [1:0]  exp_mode = 2'd0;
    logic [7:0]  fr [18];
    logic [7:0]  ex [18];
    logic [15:0] mq [$];

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] bcrc(input logic [63:0] d);
        logic [31:0] c;
        c = '1;
        for (int i = 0; i < 64; i++) begin
            logic fb;
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        return ~c;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (rcf_pulse) rcf_n++;
            if (sync_wr) begin
                syn_n++;
                syn_got = sync_data;
            end
        end
    end

    task automatic run(input logic [7:0] addr, input logic [7:0] ctrl, input logic [7:0] stat,
                       input logic [63:0] dat, input bit corrupt, input bit badhdr,
                       input int len, input string tag);
        logic [63:0] src;
        logic [31:0] c;
        bit          hit, afifo, async;
        int          r0, s0;
        hit   = !badhdr && addr == NODE && !stat[7];
        fr[0] = badhdr ? 8'h3C : 8'hC5;
        fr[1] = 8'h1A;
        fr[2] = addr;
        fr[3] = ctrl;
        fr[4] = stat;
        fr[5] = 8'h5E;
        for (int i = 0; i < 8; i++) fr[6+i] = dat[8*i +: 8];
        c = bcrc(dat);
        for (int k = 0; k < 4; k++) fr[14+k] = c[8*k +: 8] ^ ((corrupt && k == 2) ? 8'h10 : 8'h00);
        for (int i = 0; i < 18; i++) ex[i] = fr[i];
        if (hit && ctrl[1]) begin
            src = ctrl[7] ? sync_time : ret_data;
            for (int i = 0; i < 8; i++) ex[6+i] = src[8*i +: 8];
            c = bcrc(src);
            for (int k = 0; k < 4; k++) ex[14+k] = c[8*k +: 8];
        end
        afifo = hit && ctrl[0] && !ctrl[7] && !corrupt && len == 18 && (mq.size() <= DEPTH - 4);
        async = hit && ctrl[0] && ctrl[7] && !corrupt && len == 18;
        r0 = rcf_n;
        s0 = syn_n;
        for (int i = 0; i <= len; i++) begin
            @(negedge clk);
            if (i > 0)
                chk(out_valid && out_data == ex[i-1], tag, {55'd0, out_valid, out_data}, {55'd0, 1'b1, ex[i-1]});
            if (i < len) begin
                in_valid = 1'b1;
                in_data  = fr[i];
            end else begin
                in_valid = 1'b0;
                in_data  = 8'h00;
            end
        end
        @(negedge clk);
        chk(!out_valid, "R1 idle after frame", {63'd0, out_valid}, 64'd0);
        repeat (6) @(negedge clk);
        chk((rcf_n - r0) == ((afifo || async) ? 1 : 0), "R6 completion pulses",
            64'(rcf_n - r0), (afifo || async) ? 64'd1 : 64'd0);
        chk((syn_n - s0) == (async ? 1 : 0), "R7 sync strobes", 64'(syn_n - s0), async ? 64'd1 : 64'd0);
        if (async) chk(syn_got == dat, "R7 sync payload", syn_got, dat);
        if (afifo) for (int k = 0; k < 4; k++) mq.push_back(dat[16*k +: 16]);
        if (!badhdr && addr == NODE && len >= 4) exp_mode = ctrl[3:2];
        chk(cmd_mode == exp_mode, "R3 latched mode", {62'd0, cmd_mode}, {62'd0, exp_mode});
    endtask

    task automatic drain();
        while (mq.size() > 0) begin
            @(negedge clk);
            chk(!rxf_empty && rxf_data == mq[0], "R4 fifo word", {47'd0, rxf_empty, rxf_data}, {48'd0, mq[0]});
            void'(mq.pop_front());
            rxf_pop = 1'b1;
            @(negedge clk);
            rxf_pop = 1'b0;
        end
        @(negedge clk);
        chk(rxf_empty, "R12 empty after drain", {63'd0, rxf_empty}, 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] d;
        in_valid  = 1'b0;
        in_data   = 8'h00;
        rxf_pop   = 1'b0;
        node_addr = NODE;
        ret_data  = 64'hA1B2C3D4E5F60718;
        sync_time = 64'h0F1E2D3C4B5A6978;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R1 reset output", {63'd0, out_valid}, 64'd0);
        chk(rxf_empty, "R12 reset empty", {63'd0, rxf_empty}, 64'd1);
        chk(!rcf_pulse && !sync_wr, "R6 reset pulses", {62'd0, rcf_pulse, sync_wr}, 64'd0);
        chk(cmd_mode == 2'd0, "R3 reset mode", {62'd0, cmd_mode}, 64'd0);

        d = 64'h8877665544332211;
        run(NODE, 8'h01, 8'h00, d, 1'b0, 1'b0, 18, "R4 read forward");
        drain();
        run(NODE, 8'h07, 8'h00, d, 1'b0, 1'b0, 18, "R8 read then write");
        drain();
        run(8'h2B, 8'h03, 8'h00, d, 1'b0, 1'b0, 18, "R1 other node");
        run(NODE, 8'h01, 8'h00, d, 1'b1, 1'b0, 18, "R5 bad crc");
        run(NODE, 8'h0F, 8'h00, d, 1'b0, 1'b1, 18, "R2 bad header");
        run(NODE, 8'h0D, 8'h00, d, 1'b0, 1'b0, 18, "R2 recovery");
        drain();
        run(NODE, 8'h0B, 8'h80, d, 1'b0, 1'b0, 18, "R9 returning");
        run(NODE, 8'h81, 8'h00, d, 1'b0, 1'b0, 18, "R7 sync read");
        run(NODE, 8'h83, 8'h00, d, 1'b0, 1'b0, 18, "R7 sync read write");
        run(NODE, 8'h03, 8'h00, d, 1'b0, 1'b0, 10, "R11 truncated");
        run(NODE, 8'h01, 8'h00, ~d, 1'b0, 1'b0, 18, "R11 after truncation");
        drain();
        for (int i = 0; i < 5; i++)
            run(NODE, 8'h01, 8'h00, {d[63:8], 8'(i)}, 1'b0, 1'b0, 18, "R10 fill");
        drain();

        for (int n = 0; n < 40; n++) begin
            logic [7:0] a;
            int         len;
            a         = ($urandom % 3 == 0) ? 8'($urandom) : NODE;
            ret_data  = {$urandom, $urandom};
            sync_time = {$urandom, $urandom};
            len       = ($urandom % 8 == 0) ? 3 + int'($urandom % 15) : 18;
            run(a, 8'($urandom), 8'($urandom), {$urandom, $urandom},
                ($urandom % 6) == 0, ($urandom % 8) == 0, len, "R8 random frame");
            drain();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule